// File: doc/BRIEF.md
# Radio slot sequencing controller

This block sequences the power and loop controls of a time-slotted radio for one slot cycle. Starting from power-down, it runs a blind slot in which the synthesizer locks with the loop closed. It then runs the active slot, where the loop is normally opened and either the transmit or the receive path is enabled. It returns to power-down by a rule that depends on the selected bus mode. The timing comes from the serial enable line, the serial clock line, an optional power-down strobe and a slot-control input. Static configuration bits select receive or transmit, loop hold, preamplifier gating, antenna-switch source and the low-power flag. These bits are assumed to come from a separately loaded configuration register.

All inputs are sampled on the rising edge of `clk` and edges are found by comparing each sample with the one before it. Every output, including the exposed state, is a register updated on the same edge that samples the stimulus. Encodings: `bus_mode` 0 is the stop-pulse mode, 1 is the strobe mode, and 2 or 3 is the level mode. `state_o` is 0 for OFF, 1 for BLIND and 2 for ACTIVE.

Top module: `slot_sequencer`

## Requirements
- R1: A synchronous `rst` puts `state_o` at 0 (OFF) with every control output low.
- R2: In modes 0 and 1, a rise of `sen` that follows at least one `sclk` rise during the preceding `sen`-low period enters BLIND (`state_o`=1). There, `synth_on`, `loop_closed` and `vco_on` are high, and `pa_on` is high only when `cfg_rx`=0 and `cfg_pa_gate`=0.
- R3: In modes 0 and 1, a fall of `sen` in BLIND enters ACTIVE (`state_o`=2). `synth_on` and `loop_closed` drop unless `cfg_hold_loop`=1, and `rx_on` rises when `cfg_rx`=1.
- R4: In mode 0, a rise of `sen` in ACTIVE with no `sclk` rise during the preceding `sen`-low period returns to OFF. If an `sclk` rise did occur, it enters BLIND again.
- R5: In mode 1, a `sen` rise without a prior `sclk` rise has no effect. A fall of `pdn_strobe` returns to OFF from BLIND or ACTIVE, and a rise of `pdn_strobe` has no effect.
- R6: In mode 2/3, a `sen` rise enters BLIND from OFF or ACTIVE and a `sen` fall in BLIND enters ACTIVE. Whenever `sen` and `sclk` are both low, the state returns to OFF.
- R7: `rx_switch` equals `rx_on`, which is high only in ACTIVE with `cfg_rx`=1.
- R8: In transmit (`cfg_rx`=0), `tx_switch` is high throughout ACTIVE when `cfg_pa_gate`=0 and `cfg_ton_follow`=0. Otherwise it follows `slot_ctl` during ACTIVE. It is low outside ACTIVE.
- R9: With `cfg_pa_gate`=1 in transmit, `pa_on` is low in BLIND and follows `slot_ctl` in ACTIVE. With `cfg_pa_gate`=0 in transmit, `pa_on` is high in both slots.
- R10: In receive, `low_pwr` is low. In transmit it equals `cfg_low_pwr` in BLIND and ACTIVE for modes 0 and 1, and in ACTIVE only for mode 2/3.
- R11: State and outputs change on the first rising `clk` edge that samples the causing input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_mode | input | 2 | 0 stop-pulse, 1 strobe, 2/3 level |
| sen | input | 1 | Serial enable line |
| sclk | input | 1 | Serial clock line |
| pdn_strobe | input | 1 | Power-down strobe, falling edge active in mode 1 |
| slot_ctl | input | 1 | Slot-control input for gating in transmit |
| cfg_rx | input | 1 | 1 receive slot, 0 transmit slot |
| cfg_pa_gate | input | 1 | Preamplifier gated by slot_ctl in active transmit |
| cfg_ton_follow | input | 1 | Antenna transmit switch follows slot_ctl |
| cfg_hold_loop | input | 1 | Keep loop closed during active slot |
| cfg_low_pwr | input | 1 | Requested level for low_pwr in transmit |
| synth_on | output | 1 | Synthesizer powered |
| loop_closed | output | 1 | PLL loop closed |
| vco_on | output | 1 | VCO powered |
| pa_on | output | 1 | TX preamplifier enabled |
| rx_on | output | 1 | Receiver powered |
| tx_switch | output | 1 | Antenna transmit switch control |
| rx_switch | output | 1 | Antenna receive switch control |
| low_pwr | output | 1 | Low-power flag to the power amplifier |
| state_o | output | 2 | 0 OFF, 1 BLIND, 2 ACTIVE |

## Verification
Every result is due one edge after the stimulus. A change driven just after one rising edge shows on `state_o` and all outputs just after the next rising edge, because the edge detectors, the state register and the output registers all act on that same edge. The bench drives inputs 1 ns after an edge, waits for the next edge and samples 1 ns later. This places each check in the exact cycle of the response, so a spurious extra register stage or a missed edge is reported. Cases where an input must have no effect are observed over the following cycle through `state_o` and the outputs.

// File: rtl/slotseq_pkg.sv
package slotseq_pkg;
  localparam int MODE_W  = 2;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_OFF    = 2'd0,
    ST_BLIND  = 2'd1,
    ST_ACTIVE = 2'd2
  } slot_state_e;

  typedef struct packed {
    logic rx;
    logic pa_gate;
    logic ton_follow;
    logic hold_loop;
    logic low_pwr;
  } slot_cfg_t;
endpackage

// File: rtl/slotseq_edge.sv
module slotseq_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) prev <= d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise[i] = d[i] & ~prev[i];
  end
endmodule

// File: rtl/slotseq_fsm.sv
module slotseq_fsm
  import slotseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              sen,
  input  logic              sclk,
  input  logic              sen_rise,
  input  logic              sen_fall,
  input  logic              sclk_rise,
  input  logic              pdn_fall,
  output slot_state_e       state_q,
  output slot_state_e       state_nx
);
  logic seen_q;
  logic level_mode;
  logic strobe_mode;

  assign level_mode  = mode[1];
  assign strobe_mode = (mode == MODE_W'(1));

  always_comb begin
    state_nx = state_q;
    if (level_mode) begin
      if (!sen && !sclk) begin
        state_nx = ST_OFF;
      end else begin
        unique case (state_q)
          ST_OFF:    if (sen_rise) state_nx = ST_BLIND;
          ST_BLIND:  if (sen_fall) state_nx = ST_ACTIVE;
          ST_ACTIVE: if (sen_rise) state_nx = ST_BLIND;
          default:   state_nx = ST_OFF;
        endcase
      end
    end else if (strobe_mode && pdn_fall && state_q != ST_OFF) begin
      state_nx = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:    if (sen_rise && seen_q) state_nx = ST_BLIND;
        ST_BLIND:  if (sen_fall) state_nx = ST_ACTIVE;
        ST_ACTIVE: begin
          if (sen_rise) begin
            if (seen_q)            state_nx = ST_BLIND;
            else if (!strobe_mode) state_nx = ST_OFF;
          end
        end
        default:   state_nx = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_nx;
      if (sen_rise)              seen_q <= 1'b0;
      else if (sclk_rise && !sen) seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/slotseq_outdec.sv
module slotseq_outdec
  import slotseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  slot_state_e state_nx,
  input  slot_cfg_t   cfg,
  input  logic        level_mode,
  input  logic        slot_ctl,
  output logic        synth_q,
  output logic        loop_q,
  output logic        vco_q,
  output logic        pa_q,
  output logic        rx_q,
  output logic        tsw_q,
  output logic        lp_q
);
  logic tx, blind, act, on;
  logic loop_d, pa_d, tsw_d, lp_d;

  always_comb begin
    tx     = ~cfg.rx;
    blind  = (state_nx == ST_BLIND);
    act    = (state_nx == ST_ACTIVE);
    on     = (state_nx != ST_OFF);
    loop_d = blind | (act & cfg.hold_loop);
    pa_d   = tx & ((blind & ~cfg.pa_gate) |
                   (act & (cfg.pa_gate ? slot_ctl : 1'b1)));
    tsw_d  = tx & act & ((cfg.pa_gate | cfg.ton_follow) ? slot_ctl : 1'b1);
    lp_d   = tx & cfg.low_pwr & (level_mode ? act : on);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      synth_q <= 1'b0;
      loop_q  <= 1'b0;
      vco_q   <= 1'b0;
      pa_q    <= 1'b0;
      rx_q    <= 1'b0;
      tsw_q   <= 1'b0;
      lp_q    <= 1'b0;
    end else begin
      synth_q <= loop_d;
      loop_q  <= loop_d;
      vco_q   <= on;
      pa_q    <= pa_d;
      rx_q    <= act & cfg.rx;
      tsw_q   <= tsw_d;
      lp_q    <= lp_d;
    end
  end
endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer
  import slotseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [MODE_W-1:0]  bus_mode,
  input  logic               sen,
  input  logic               sclk,
  input  logic               pdn_strobe,
  input  logic               slot_ctl,
  input  logic               cfg_rx,
  input  logic               cfg_pa_gate,
  input  logic               cfg_ton_follow,
  input  logic               cfg_hold_loop,
  input  logic               cfg_low_pwr,
  output logic               synth_on,
  output logic               loop_closed,
  output logic               vco_on,
  output logic               pa_on,
  output logic               rx_on,
  output logic               tx_switch,
  output logic               rx_switch,
  output logic               low_pwr,
  output logic [STATE_W-1:0] state_o
);
  logic [1:0]  rises;
  logic [1:0]  falls;
  slot_state_e state_q, state_nx;
  slot_cfg_t   cfg;

  assign cfg = '{rx: cfg_rx, pa_gate: cfg_pa_gate, ton_follow: cfg_ton_follow,
                 hold_loop: cfg_hold_loop, low_pwr: cfg_low_pwr};

  slotseq_edge #(.W(2)) u_rise (
    .clk (clk),
    .d   ({sclk, sen}),
    .rise(rises)
  );

  slotseq_edge #(.W(2)) u_fall (
    .clk (clk),
    .d   ({~pdn_strobe, ~sen}),
    .rise(falls)
  );

  slotseq_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .mode     (bus_mode),
    .sen      (sen),
    .sclk     (sclk),
    .sen_rise (rises[0]),
    .sen_fall (falls[0]),
    .sclk_rise(rises[1]),
    .pdn_fall (falls[1]),
    .state_q  (state_q),
    .state_nx (state_nx)
  );

  slotseq_outdec u_dec (
    .clk       (clk),
    .rst       (rst),
    .state_nx  (state_nx),
    .cfg       (cfg),
    .level_mode(bus_mode[1]),
    .slot_ctl  (slot_ctl),
    .synth_q   (synth_on),
    .loop_q    (loop_closed),
    .vco_q     (vco_on),
    .pa_q      (pa_on),
    .rx_q      (rx_on),
    .tsw_q     (tx_switch),
    .lp_q      (low_pwr)
  );

  assign rx_switch = rx_on;
  assign state_o   = state_q;
endmodule

// File: rtl/slot_sequencer_chk.sv
module slot_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_rx,
  input logic       loop_closed,
  input logic       vco_on,
  input logic       pa_on,
  input logic       rx_on,
  input logic       tx_switch,
  input logic       rx_switch,
  input logic [1:0] state_o
);
  AST_RESET_TO_OFF: assert property (@(posedge clk)
    rst |=> (state_o == 2'd0 && !vco_on && !pa_on && !rx_on)); // R1
  AST_LOOP_NEEDS_VCO: assert property (@(posedge clk) disable iff (rst)
    loop_closed |-> vco_on); // R2
  AST_ACTIVE_AFTER_BLIND: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd2) |-> ($past(state_o) != 2'd0)); // R3
  AST_RX_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (rx_on || rx_switch) |-> (state_o == 2'd2 && cfg_rx)); // R7
  AST_TSW_ONLY_ACTIVE_TX: assert property (@(posedge clk) disable iff (rst)
    tx_switch |-> (state_o == 2'd2 && !cfg_rx)); // R8
  AST_PA_NOT_IN_RX: assert property (@(posedge clk) disable iff (rst)
    pa_on |-> (!cfg_rx && state_o != 2'd0)); // R9
endmodule

bind slot_sequencer slot_sequencer_chk u_chk (.*);

// File: tb/slot_sequencer_bench.sv
module slot_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_mode = 2'd0;
  logic       sen = 1'b0, sclk = 1'b0, pdn_strobe = 1'b1, slot_ctl = 1'b0;
  logic       cfg_rx = 1'b0, cfg_pa_gate = 1'b0, cfg_ton_follow = 1'b0;
  logic       cfg_hold_loop = 1'b0, cfg_low_pwr = 1'b0;
  logic       synth_on, loop_closed, vco_on, pa_on, rx_on;
  logic       tx_switch, rx_switch, low_pwr;
  logic [1:0] state_o;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slot_sequencer u_slot_sequencer (.*);

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // outs = {synth_on, loop_closed, vco_on, pa_on, rx_on, tx_switch, rx_switch, low_pwr}
  task automatic expect_all(string req, logic [1:0] st, logic [7:0] outs);
    logic [7:0] got;
    got = {synth_on, loop_closed, vco_on, pa_on, rx_on, tx_switch, rx_switch, low_pwr};
    checks++;
    if (state_o !== st) begin
      failures++;
      $display("FAIL %s state actual=%0d expected=%0d", req, state_o, st);
    end
    checks++;
    if (got !== outs) begin
      failures++;
      $display("FAIL %s outputs actual=%b expected=%b", req, got, outs);
    end
  endtask

  task automatic set_cfg(logic rx, logic gate, logic tf, logic hold, logic lp);
    cfg_rx = rx; cfg_pa_gate = gate; cfg_ton_follow = tf;
    cfg_hold_loop = hold; cfg_low_pwr = lp;
  endtask

  task automatic clock_pulse();
    sclk = 1'b1; step();
    sclk = 1'b0; step();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(); step();
    expect_all("R1", 2'd0, 8'b0000_0000);
    rst = 1'b0;
    step();
    expect_all("R1", 2'd0, 8'b0000_0000);
  endtask

  task automatic t_stop_tx();
    bus_mode = 2'd0; set_cfg(0, 0, 0, 0, 1);
    clock_pulse();
    sen = 1'b1; step();
    expect_all("R2 R10 R11", 2'd1, 8'b1111_0001);
    sen = 1'b0; step();
    expect_all("R3 R8 R10", 2'd2, 8'b0011_0101);
    sen = 1'b1; step();
    expect_all("R4 stop", 2'd0, 8'b0000_0000);
    sen = 1'b0; step();
  endtask

  task automatic t_stop_rx();
    bus_mode = 2'd0; set_cfg(1, 0, 0, 1, 1);
    clock_pulse();
    sen = 1'b1; step();
    expect_all("R2 R10 rx blind", 2'd1, 8'b1110_0000);
    sen = 1'b0; step();
    expect_all("R3 R7 hold", 2'd2, 8'b1110_1010);
    clock_pulse();
    expect_all("R4 clocks in active", 2'd2, 8'b1110_1010);
    sen = 1'b1; step();
    expect_all("R4 new blind", 2'd1, 8'b1110_0000);
    sen = 1'b0; step();
    sen = 1'b1; step();
    expect_all("R4 stop rx", 2'd0, 8'b0000_0000);
    sen = 1'b0; step();
  endtask

  task automatic t_strobe();
    bus_mode = 2'd1; set_cfg(0, 0, 0, 0, 0);
    clock_pulse();
    sen = 1'b1; step();
    sen = 1'b0; step();
    expect_all("R3 strobe mode", 2'd2, 8'b0011_0100);
    sen = 1'b1; step();
    expect_all("R5 stop pulse ignored", 2'd2, 8'b0011_0100);
    sen = 1'b0; step();
    pdn_strobe = 1'b0; step();
    expect_all("R5 strobe fall", 2'd0, 8'b0000_0000);
    pdn_strobe = 1'b1; step();
    expect_all("R5 strobe rise ignored", 2'd0, 8'b0000_0000);
    clock_pulse();
    sen = 1'b1; step();
    expect_all("R2 strobe mode", 2'd1, 8'b1111_0000);
    pdn_strobe = 1'b0; step();
    expect_all("R5 strobe in blind", 2'd0, 8'b0000_0000);
    sen = 1'b0; step();
    pdn_strobe = 1'b1; step();
  endtask

  task automatic t_gate();
    bus_mode = 2'd0; set_cfg(0, 1, 0, 0, 0); slot_ctl = 1'b0;
    clock_pulse();
    sen = 1'b1; step();
    expect_all("R9 gate blind", 2'd1, 8'b1110_0000);
    sen = 1'b0; step();
    expect_all("R9 R8 gate low", 2'd2, 8'b0010_0000);
    slot_ctl = 1'b1; step();
    expect_all("R9 R8 gate high", 2'd2, 8'b0011_0100);
    slot_ctl = 1'b0; step();
    expect_all("R9 R8 gate back", 2'd2, 8'b0010_0000);
    sen = 1'b1; step(); sen = 1'b0; step();
    set_cfg(0, 0, 1, 0, 0);
    clock_pulse();
    sen = 1'b1; step();
    expect_all("R8 follow blind", 2'd1, 8'b1111_0000);
    sen = 1'b0; step();
    expect_all("R8 follow low", 2'd2, 8'b0011_0000);
    slot_ctl = 1'b1; step();
    expect_all("R8 follow high", 2'd2, 8'b0011_0100);
    slot_ctl = 1'b0;
    sen = 1'b1; step(); sen = 1'b0; step();
    expect_all("R4 after follow", 2'd0, 8'b0000_0000);
  endtask

  task automatic t_level();
    bus_mode = 2'd2; set_cfg(0, 0, 0, 0, 1);
    sen = 1'b1; step();
    expect_all("R6 R10 level blind", 2'd1, 8'b1111_0000);
    clock_pulse();
    expect_all("R6 programming", 2'd1, 8'b1111_0000);
    sclk = 1'b1; step();
    sen = 1'b0; step();
    expect_all("R6 R10 level active", 2'd2, 8'b0011_0101);
    sen = 1'b1; step();
    expect_all("R6 reprogram", 2'd1, 8'b1111_0000);
    sen = 1'b0; step();
    sclk = 1'b0; step();
    expect_all("R6 level off", 2'd0, 8'b0000_0000);
  endtask

  initial begin
    t_reset();
    t_stop_tx();
    t_stop_rx();
    t_strobe();
    t_gate();
    t_level();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule